// File: doc/BRIEF.md
# Dual-Port RAM Collision Arbiter

A synchronous 1024 x 8 memory with two fully independent ports, left and right, each able to read or write any word. Every port has an active-low chip enable, an active-low write select (low = write, high = read) and an active-low output enable, plus a 10-bit address, write data and read data. All inputs are sampled on the rising clock edge. Writes commit at that edge. Read data is registered at that edge from the contents the memory held before any write at the same edge.

An arbitration state machine watches both ports every cycle. When both ports are enabled on the same address, it picks one port to own the word and lowers the other port's active-low busy flag. The owner is the port that was already enabled on that address in the previous cycle. The losing port's writes are dropped. If the owner writes while the loser is reading, the loser's read data is frozen until a release event occurs. The state machine has three states:
- ST_FREE: no collision.
- ST_LEFT_OWNS: the right port is busy.
- ST_RIGHT_OWNS: the left port is busy.

Its transitions are:
- ST_FREE to ST_LEFT_OWNS on a match where the left port was there first, or where neither port was (tie).
- ST_FREE to ST_RIGHT_OWNS on a match where only the right port was there first.
- Either owning state back to ST_FREE when no match is sampled.
- Either owning state to itself while the match holds.

With the parameter `IS_SLAVE` set, there is no arbitration. Each port's busy input is used instead: a low busy input inhibits that port's writes, and the busy outputs stay high.

Top module: `dpr_collide_top`

## Requirements
- R1: After reset both busy outputs are 1 and both read data outputs are 0.
- R2: A port writes `wdata` to `addr` at a rising edge where its `ce_n`=0 and `we_n`=0. It registers `mem[addr]` at an edge where `ce_n`=0 and `we_n`=1. The two ports work independently on different addresses, including two writes in the same cycle.
- R3: A port's `rdata` reads 0 whenever its `ce_n`=1 or its `oe_n`=1.
- R4: Both ports reading the same address in the same cycle both receive that word.
- R5: When a match is sampled in ST_FREE and only one port was enabled on that same address in the previous cycle, that port wins. The other port's `busy_n` is 0 from that edge on, for as long as the match is sampled.
- R6: When a match is sampled in ST_FREE and neither port was already on the address, the left port wins: `r_busy_n`=0 and `l_busy_n`=1.
- R7: A losing port's write is not performed, including in the first cycle of the match.
- R8: Both busy outputs return to 1 after the first edge at which no match is sampled, for example when the owner raises `ce_n`.
- R9: If the owner writes the matched word while the loser reads it, the loser's `rdata` keeps the pre-write value as long as the loser keeps losing with unchanged `addr`, `ce_n` and `we_n`.
- R10: The frozen value is released, and the current word is loaded at that edge, when the loser's busy clears or the loser's `addr`, `ce_n` or `we_n` differs from the previous cycle.
- R11: With `IS_SLAVE`=1, a port's write is inhibited while its `busy_in_n`=0, and both `busy_n` outputs stay 1. With `IS_SLAVE`=0, the `busy_in_n` inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write select, 0 = write, 1 = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 10 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_busy_in_n | input | 1 | Left busy input, used in slave mode only |
| l_rdata | output | 8 | Left read data, 0 when disabled |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write select, 0 = write, 1 = read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 10 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_busy_in_n | input | 1 | Right busy input, used in slave mode only |
| r_rdata | output | 8 | Right read data, 0 when disabled |
| r_busy_n | output | 1 | Right busy flag, active low |

## Verification
Collisions are tried in three arrival orders:
- The left port arrives first, then the right port joins with a write. This shows that first-come priority drops the late writer.
- The right port arrives first, then the left port joins. This shows that priority is decided by arrival order and not by a fixed side.
- Both ports arrive together on fresh writes. This isolates the left-wins tie rule.

An owner write under a reading loser is followed by three continuations:
- Nothing changes, which should keep the data frozen.
- Both ports move together to a new shared address, so busy persists and only the address-change release applies.
- The owner leaves, which shows the busy-clear release.

A separate slave instance shows that writes are gated by the busy input. The master instance runs with its busy inputs held low throughout, so every successful master write also shows that those inputs are ignored.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    typedef enum logic [1:0] {
        ST_FREE       = 2'd0,
        ST_LEFT_OWNS  = 2'd1,
        ST_RIGHT_OWNS = 2'd2
    } arb_state_e;
endpackage

// File: rtl/dpr_mem_array.sv
module dpr_mem_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          l_wr,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    input  logic          r_wr,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] l_q,
    output logic [DW-1:0] r_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Arbitration guarantees the two strobes never target one word together.
    always_ff @(posedge clk) begin
        if (l_wr) cells[l_addr] <= l_wdata;
        if (r_wr) cells[r_addr] <= r_wdata;
    end

    // Combinational read of the contents before this edge's writes.
    assign l_q = cells[l_addr];
    assign r_q = cells[r_addr];
endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpr_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_ce_n,
    input  logic          r_ce_n,
    input  logic [AW-1:0] l_addr,
    input  logic [AW-1:0] r_addr,
    input  logic          l_prev_ce_n,
    input  logic          r_prev_ce_n,
    input  logic [AW-1:0] l_prev_addr,
    input  logic [AW-1:0] r_prev_addr,
    output logic          l_lose,
    output logic          r_lose,
    output logic          l_busy_n,
    output logic          r_busy_n
);
    arb_state_e state_q, state_d;
    logic match, l_stay, r_stay;

    assign match  = !l_ce_n && !r_ce_n && (l_addr == r_addr);
    assign l_stay = !l_prev_ce_n && (l_prev_addr == l_addr);
    assign r_stay = !r_prev_ce_n && (r_prev_addr == r_addr);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (match) begin
                    if (r_stay && !l_stay) state_d = ST_RIGHT_OWNS;
                    else                   state_d = ST_LEFT_OWNS;
                end
            end
            ST_LEFT_OWNS: begin
                if (!match) state_d = ST_FREE;
            end
            ST_RIGHT_OWNS: begin
                if (!match) state_d = ST_FREE;
            end
            default: state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        l_lose   = (state_d == ST_RIGHT_OWNS);
        r_lose   = (state_d == ST_LEFT_OWNS);
        l_busy_n = (state_q != ST_RIGHT_OWNS);
        r_busy_n = (state_q != ST_LEFT_OWNS);
    end

    assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> (l_busy_n && r_busy_n));

    assert_tie_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE && match && !l_stay && !r_stay) |=> (!r_busy_n && l_busy_n));

    assert_first_come_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE && match && r_stay && !l_stay) |=> (!l_busy_n && r_busy_n));
endmodule

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic          lose,
    input  logic          other_wr_here,
    input  logic [DW-1:0] mem_q,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] prev_addr,
    output logic          prev_ce_n
);
    logic          prev_we_n;
    logic          hold_q;
    logic [DW-1:0] rdata_q;
    logic          release_w, keep, load;

    assign release_w = !lose || (addr != prev_addr) || (ce_n != prev_ce_n) || (we_n != prev_we_n);
    assign keep      = hold_q && !release_w;
    assign load      = !ce_n && we_n && !keep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_addr <= '0;
            prev_ce_n <= 1'b1;
            prev_we_n <= 1'b1;
            hold_q    <= 1'b0;
            rdata_q   <= '0;
        end else begin
            prev_addr <= addr;
            prev_ce_n <= ce_n;
            prev_we_n <= we_n;
            hold_q    <= keep || (lose && other_wr_here);
            if (load) rdata_q <= mem_q;
        end
    end

    assign rdata = (ce_n || oe_n) ? '0 : rdata_q;

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && lose && !ce_n && (addr == prev_addr) && (ce_n == prev_ce_n) && (we_n == prev_we_n))
        |=> $stable(rdata_q));
endmodule

// File: rtl/dpr_collide_top.sv
module dpr_collide_top #(
    parameter int AW       = 10,
    parameter int DW       = 8,
    parameter bit IS_SLAVE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_ce_n,
    input  logic          l_we_n,
    input  logic          l_oe_n,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    input  logic          l_busy_in_n,
    output logic [DW-1:0] l_rdata,
    output logic          l_busy_n,
    input  logic          r_ce_n,
    input  logic          r_we_n,
    input  logic          r_oe_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    input  logic          r_busy_in_n,
    output logic [DW-1:0] r_rdata,
    output logic          r_busy_n
);
    logic          l_lose, r_lose, l_wr, r_wr;
    logic          arb_l_lose, arb_r_lose, arb_l_busy_n, arb_r_busy_n;
    logic [DW-1:0] l_q, r_q;
    logic [AW-1:0] l_prev_addr, r_prev_addr;
    logic          l_prev_ce_n, r_prev_ce_n;

    dpr_arbiter #(.AW(AW)) arb_i (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .r_ce_n(r_ce_n),
        .l_addr(l_addr), .r_addr(r_addr),
        .l_prev_ce_n(l_prev_ce_n), .r_prev_ce_n(r_prev_ce_n),
        .l_prev_addr(l_prev_addr), .r_prev_addr(r_prev_addr),
        .l_lose(arb_l_lose), .r_lose(arb_r_lose),
        .l_busy_n(arb_l_busy_n), .r_busy_n(arb_r_busy_n)
    );

    // Slave variant: the busy inputs replace the local arbitration.
    assign l_lose   = IS_SLAVE ? !l_busy_in_n : arb_l_lose;
    assign r_lose   = IS_SLAVE ? !r_busy_in_n : arb_r_lose;
    assign l_busy_n = IS_SLAVE ? 1'b1 : arb_l_busy_n;
    assign r_busy_n = IS_SLAVE ? 1'b1 : arb_r_busy_n;

    assign l_wr = !l_ce_n && !l_we_n && !l_lose;
    assign r_wr = !r_ce_n && !r_we_n && !r_lose;

    dpr_mem_array #(.AW(AW), .DW(DW)) mem_i (
        .clk(clk),
        .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata),
        .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata),
        .l_q(l_q), .r_q(r_q)
    );

    dpr_port_ctrl #(.AW(AW), .DW(DW)) lport_i (
        .clk(clk), .rst_n(rst_n),
        .ce_n(l_ce_n), .we_n(l_we_n), .oe_n(l_oe_n), .addr(l_addr),
        .lose(l_lose), .other_wr_here(r_wr && (r_addr == l_addr)),
        .mem_q(l_q), .rdata(l_rdata),
        .prev_addr(l_prev_addr), .prev_ce_n(l_prev_ce_n)
    );

    dpr_port_ctrl #(.AW(AW), .DW(DW)) rport_i (
        .clk(clk), .rst_n(rst_n),
        .ce_n(r_ce_n), .we_n(r_we_n), .oe_n(r_oe_n), .addr(r_addr),
        .lose(r_lose), .other_wr_here(l_wr && (l_addr == r_addr)),
        .mem_q(r_q), .rdata(r_rdata),
        .prev_addr(r_prev_addr), .prev_ce_n(r_prev_ce_n)
    );

    assert_single_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !IS_SLAVE |-> !(l_wr && r_wr && (l_addr == r_addr)));

    assert_slave_busy_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        IS_SLAVE |-> (l_busy_n && r_busy_n));
endmodule

// File: tb/dpr_collide_top_tb_top.sv
`timescale 1ns/1ps
module dpr_collide_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       l_ce_n = 1, l_we_n = 1, l_oe_n = 1, r_ce_n = 1, r_we_n = 1, r_oe_n = 1;
    logic [9:0] l_addr = 0, r_addr = 0;
    logic [7:0] l_wdata = 0, r_wdata = 0;
    logic [7:0] l_rdata, r_rdata;
    logic       l_busy_n, r_busy_n;

    logic       s_ce_n = 1, s_we_n = 1, s_oe_n = 1, s_busy_in_n = 1;
    logic [9:0] s_addr = 0;
    logic [7:0] s_wdata = 0;
    logic [7:0] s_rdata, s_r_rdata;
    logic       s_busy_n, s_r_busy_n;

    // Master instance: busy inputs held low throughout (R11: ignored).
    dpr_collide_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_busy_in_n(1'b0), .l_rdata(l_rdata), .l_busy_n(l_busy_n),
        .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_busy_in_n(1'b0), .r_rdata(r_rdata), .r_busy_n(r_busy_n)
    );

    dpr_collide_top #(.IS_SLAVE(1'b1)) dut_slave_i (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(s_ce_n), .l_we_n(s_we_n), .l_oe_n(s_oe_n), .l_addr(s_addr),
        .l_wdata(s_wdata), .l_busy_in_n(s_busy_in_n), .l_rdata(s_rdata), .l_busy_n(s_busy_n),
        .r_ce_n(1'b1), .r_we_n(1'b1), .r_oe_n(1'b1), .r_addr(10'd0),
        .r_wdata(8'd0), .r_busy_in_n(1'b1), .r_rdata(s_r_rdata), .r_busy_n(s_r_busy_n)
    );

    typedef struct {
        int         sig;
        logic [7:0] exp;
        string      req;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    function automatic logic [7:0] observe(int sig);
        case (sig)
            0: return l_rdata;
            1: return r_rdata;
            2: return {7'd0, l_busy_n};
            3: return {7'd0, r_busy_n};
            4: return s_rdata;
            default: return {7'd0, s_busy_n};
        endcase
    endfunction

    // Driver side: queue what the next edge must produce.
    task automatic expect_v(int sig, logic [7:0] exp, string req);
        sb_item_t it;
        it.sig = sig; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic l_set(logic ce, logic we, logic oe, logic [9:0] a, logic [7:0] d);
        l_ce_n = ce; l_we_n = we; l_oe_n = oe; l_addr = a; l_wdata = d;
    endtask

    task automatic r_set(logic ce, logic we, logic oe, logic [9:0] a, logic [7:0] d);
        r_ce_n = ce; r_we_n = we; r_oe_n = oe; r_addr = a; r_wdata = d;
    endtask

    // Monitor: compare away from the edge, after the registers settle.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = observe(it.sig);
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s sig%0d actual=%h expected=%h", it.req, it.sig, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_v(0, 8'h00, "R1"); expect_v(1, 8'h00, "R1");
        expect_v(2, 8'h01, "R1"); expect_v(3, 8'h01, "R1");
        @(negedge clk);
        l_set(0, 0, 1, 10'h005, 8'hA5); r_set(1, 1, 1, 0, 0);
        expect_v(2, 8'h01, "R2");
        @(negedge clk);
        l_set(0, 0, 1, 10'h012, 8'hC3); r_set(0, 0, 1, 10'h3FF, 8'h3C);
        @(negedge clk);
        l_set(0, 1, 0, 10'h3FF, 0); r_set(0, 1, 0, 10'h005, 0);
        expect_v(0, 8'h3C, "R2"); expect_v(1, 8'hA5, "R2");
        @(negedge clk);
        // right was already on 005: right owns, left busy
        l_set(0, 1, 0, 10'h005, 0);
        expect_v(0, 8'hA5, "R4"); expect_v(1, 8'hA5, "R4");
        expect_v(2, 8'h00, "R5"); expect_v(3, 8'h01, "R5");
        @(negedge clk);
        l_set(1, 1, 0, 10'h005, 0);
        expect_v(0, 8'h00, "R3"); expect_v(2, 8'h01, "R8"); expect_v(1, 8'hA5, "R2");
        @(negedge clk);
        l_set(0, 0, 1, 10'h010, 8'h11);
        @(negedge clk);
        l_set(0, 1, 0, 10'h010, 0); r_set(1, 1, 1, 0, 0);
        expect_v(0, 8'h11, "R2");
        @(negedge clk);
        // left first on 010; right joins with a write that must be dropped
        r_set(0, 0, 1, 10'h010, 8'h77);
        expect_v(3, 8'h00, "R5"); expect_v(2, 8'h01, "R5");
        expect_v(0, 8'h11, "R5"); expect_v(1, 8'h00, "R3");
        @(negedge clk);
        r_set(1, 1, 1, 0, 0);
        expect_v(0, 8'h11, "R7"); expect_v(3, 8'h01, "R8");
        @(negedge clk);
        r_set(0, 1, 0, 10'h010, 0);
        expect_v(1, 8'h11, "R5"); expect_v(3, 8'h00, "R5");
        @(negedge clk);
        // owner writes under a reading loser
        l_set(0, 0, 1, 10'h010, 8'h99);
        expect_v(1, 8'h11, "R9");
        @(negedge clk);
        l_set(0, 1, 0, 10'h010, 0);
        expect_v(1, 8'h11, "R9"); expect_v(3, 8'h00, "R9");
        @(negedge clk);
        l_set(1, 1, 1, 10'h010, 0);
        expect_v(1, 8'h99, "R10"); expect_v(3, 8'h01, "R8");
        @(negedge clk);
        // right stayed on 010, left joins: right owns
        l_set(0, 1, 0, 10'h010, 0);
        expect_v(0, 8'h99, "R5"); expect_v(2, 8'h00, "R5");
        @(negedge clk);
        r_set(0, 0, 1, 10'h010, 8'h5A);
        expect_v(0, 8'h99, "R9");
        @(negedge clk);
        // both move to 012: busy persists, address change releases
        l_set(0, 1, 0, 10'h012, 0); r_set(0, 1, 1, 10'h012, 0);
        expect_v(0, 8'hC3, "R10"); expect_v(2, 8'h00, "R10");
        @(negedge clk);
        l_set(0, 1, 0, 10'h010, 0); r_set(1, 1, 1, 0, 0);
        expect_v(0, 8'h5A, "R7"); expect_v(2, 8'h01, "R8");
        @(negedge clk);
        l_set(0, 1, 1, 10'h010, 0);
        expect_v(0, 8'h00, "R3");
        @(negedge clk);
        l_set(1, 1, 1, 0, 0);
        @(negedge clk);
        // tie: both arrive fresh with writes
        l_set(0, 0, 1, 10'h040, 8'h12); r_set(0, 0, 1, 10'h040, 8'h34);
        expect_v(3, 8'h00, "R6"); expect_v(2, 8'h01, "R6");
        @(negedge clk);
        l_set(1, 1, 1, 0, 0); r_set(1, 1, 1, 0, 0);
        expect_v(3, 8'h01, "R8");
        @(negedge clk);
        r_set(0, 1, 0, 10'h040, 0);
        expect_v(1, 8'h12, "R6");
        @(negedge clk);
        r_set(1, 1, 1, 0, 0);
        // slave instance
        s_ce_n = 0; s_we_n = 0; s_oe_n = 1; s_addr = 10'h001; s_wdata = 8'hAA; s_busy_in_n = 1;
        @(negedge clk);
        s_wdata = 8'hBB; s_busy_in_n = 0;
        expect_v(5, 8'h01, "R11");
        @(negedge clk);
        s_we_n = 1; s_oe_n = 0; s_busy_in_n = 1;
        expect_v(4, 8'hAA, "R11"); expect_v(5, 8'h01, "R11");
        @(negedge clk);
        s_ce_n = 1;
        @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule